// File: doc/BRIEF.md
# Random-Source Event Interrupt Aggregator

This block gathers the event strobes of a random-number core and reduces them to one level-sensitive interrupt line. A completion event and two fault events (a continuous-output test fault and an entropy health fault) each set a sticky flag in a core status register. Software picks which flags may raise the core interrupt through enable bits in an interrupt-control register, and clears flags by writing one to separate clear bits in that same register.

The flags and their enables feed one core bit in a top-level status register. That register also holds a bus-error bit that an external strobe sets. Both bits are write-one-to-clear. A two-bit mask gates the top-level status onto `irq`. Software cannot write the mask directly. It changes the mask only through a mask-enable register, which clears mask bits and so lets interrupts through, and a mask-disable register, which sets them. A soft-reset strobe wipes the core flags and the core bit.

A three-state mode machine follows the block's surroundings. Its states are MODE_HELD, MODE_QUIET and MODE_LIVE. It enters MODE_HELD whenever `hold_reset` is high. It enters MODE_QUIET when the block is not held and `src_en` is low. It enters MODE_LIVE when the block is not held and `src_en` is high. These transitions are re-evaluated on every clock, and reset enters MODE_HELD. Fault strobes are accepted only in MODE_LIVE. Completion strobes are accepted in MODE_QUIET and MODE_LIVE. In MODE_HELD every flag and the core bit are held clear.

Top module: `rng_irq_agg`

## Requirements
- R1: After reset, the mask (offset 0x0C) reads 0x3, and the interrupt-control register (0x00), core status (0x04) and top-level status (0x08) read 0. `irq` is low.
- R2: In core status at 0x04, a completion strobe sets bit 0, a continuous-test fault strobe sets bit 1 and a health fault strobe sets bit 3. Each flag is set at the clock edge that samples its strobe. The flag stays set until it is cleared. If a strobe and a clear of the same flag arrive in the same cycle, the strobe wins.
- R3: At 0x00, bits 0, 1 and 2 are stored enables for completion, continuous-test fault and health fault, and they read back. Writing 1 to bit 3, 4 or 5 clears the completion, continuous-test or health flag respectively. Bits 3 to 5 always read 0.
- R4: Bit 0 of the top-level status (0x08) becomes 1 one cycle after any flag is 1 while its enable is 1. It is recomputed every cycle. A write of 1 to it clears it only when no enabled flag is set. Once set, it stays set after the condition ends, until it is cleared.
- R5: A `bus_err` strobe sets bit 1 of the top-level status. Writing 1 to that bit clears it. Writing 0 leaves it unchanged.
- R6: The mask resets to 0x3. Writes to offset 0x0C have no effect on it.
- R7: Writing offset 0x10 clears every mask bit written as 1. Writing offset 0x14 sets every mask bit written as 1. Both offsets read 0.
- R8: `irq` is high exactly when some top-level status bit is 1 and its mask bit is 0.
- R9: A `soft_rst` strobe clears all core flags and the core bit at the next edge. The enables and the bus-error bit keep their values.
- R10: The mode follows `hold_reset` and `src_en` one cycle late. In MODE_QUIET, fault strobes are ignored and completion strobes are still accepted. In MODE_HELD, all strobes are ignored and the flags and the core bit are held at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Single-cycle register write strobe |
| addr | input | ADDR_W | Byte offset of the register accessed |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data for `addr`, combinational |
| ev_done | input | 1 | Completion event strobe |
| ev_ctest_fault | input | 1 | Continuous-output test fault strobe |
| ev_health_fault | input | 1 | Entropy health fault strobe |
| bus_err | input | 1 | Bus-error event strobe |
| src_en | input | 1 | Entropy source enabled |
| hold_reset | input | 1 | Block held in reset |
| soft_rst | input | 1 | Soft-reset strobe |
| irq | output | 1 | Level interrupt output |

## Verification
On every cycle, the assertions check the following. Direct mask writes must leave the mask unchanged. Mask-enable and mask-disable writes must land in the mask. A fully set mask must silence `irq`. An enabled flag must raise the core bit on the next cycle. A soft reset or MODE_HELD must leave flags and the core bit clear. A fault flag must not appear outside MODE_LIVE. Some behaviours only the bench scenarios show. These are the exact flag bit positions in the read data, and the rule that a strobe wins over a clear in the same cycle. They also include the refusal of a core-bit clear while its condition holds, the survival of enables and the bus-error bit across a soft reset, and the readback of the write-only registers as zero.

// File: rtl/rng_irq_pkg.sv
package rng_irq_pkg;

    // register byte offsets
    localparam int unsigned OFS_ICTL  = 32'h00;
    localparam int unsigned OFS_CSTAT = 32'h04;
    localparam int unsigned OFS_TSTAT = 32'h08;
    localparam int unsigned OFS_MASK  = 32'h0C;
    localparam int unsigned OFS_MEN   = 32'h10;
    localparam int unsigned OFS_MDIS  = 32'h14;

    // number of core events and top-level status bits
    localparam int unsigned NEV  = 3;
    localparam int unsigned TS_W = 2;

    // core status read positions (done, continuous test, health)
    localparam int unsigned CS_POS_DONE = 0;
    localparam int unsigned CS_POS_CTF  = 1;
    localparam int unsigned CS_POS_HTF  = 3;

    // interrupt-control: enables at [NEV-1:0], clears at [2*NEV-1:NEV]
    localparam int unsigned IC_CLR_LSB = NEV;

    // top-level status positions
    localparam int unsigned TS_CORE = 0;
    localparam int unsigned TS_SLV  = 1;

    typedef enum logic [1:0] {
        MODE_HELD  = 2'd0,
        MODE_QUIET = 2'd1,
        MODE_LIVE  = 2'd2
    } mode_e;

endpackage

// File: rtl/rng_irq_mode_fsm.sv
module rng_irq_mode_fsm
    import rng_irq_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  hold_reset,
    input  logic  src_en,
    output mode_e mode,
    output logic  accept_done,
    output logic  accept_fault,
    output logic  held
);

    mode_e mode_q;
    mode_e mode_d;

    always_comb begin
        if (hold_reset) begin
            mode_d = MODE_HELD;
        end else if (src_en) begin
            mode_d = MODE_LIVE;
        end else begin
            mode_d = MODE_QUIET;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= MODE_HELD;
        end else begin
            mode_q <= mode_d;
        end
    end

    always_comb begin
        accept_done  = 1'b0;
        accept_fault = 1'b0;
        held         = 1'b0;
        unique case (mode_q)
            MODE_HELD: begin
                held = 1'b1;
            end
            MODE_QUIET: begin
                accept_done = 1'b1;
            end
            MODE_LIVE: begin
                accept_done  = 1'b1;
                accept_fault = 1'b1;
            end
            default: begin
                held = 1'b1;
            end
        endcase
    end

    assign mode = mode_q;

endmodule

// File: rtl/rng_irq_core_flags.sv
module rng_irq_core_flags #(
    parameter int unsigned NEV = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NEV-1:0] ev,
    input  logic           accept_done,
    input  logic           accept_fault,
    input  logic           wipe,
    input  logic           ena_wr,
    input  logic [NEV-1:0] ena_wdata,
    input  logic [NEV-1:0] clr,
    output logic [NEV-1:0] ena_q,
    output logic [NEV-1:0] flags_q,
    output logic           core_cond
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ena_q <= '0;
        end else if (ena_wr) begin
            ena_q <= ena_wdata;
        end
    end

    for (genvar i = 0; i < NEV; i++) begin : g_flag
        logic take;
        logic q;
        if (i == 0) begin : g_done
            assign take = ev[i] & accept_done;
        end else begin : g_fault
            assign take = ev[i] & accept_fault;
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q <= 1'b0;
            end else if (wipe) begin
                q <= 1'b0;
            end else if (take) begin
                q <= 1'b1;
            end else if (clr[i]) begin
                q <= 1'b0;
            end
        end
        assign flags_q[i] = q;
    end

    assign core_cond = |(flags_q & ena_q);

endmodule

// File: rtl/rng_irq_top_level.sv
module rng_irq_top_level #(
    parameter int unsigned TS_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [TS_W-1:0] set_vec,
    input  logic [TS_W-1:0] kill_vec,
    input  logic            w1c_wr,
    input  logic            men_wr,
    input  logic            mdis_wr,
    input  logic [TS_W-1:0] wbits,
    output logic [TS_W-1:0] tstat_q,
    output logic [TS_W-1:0] mask_q,
    output logic            irq
);

    for (genvar i = 0; i < TS_W; i++) begin : g_stat
        logic q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q <= 1'b0;
            end else if (kill_vec[i]) begin
                q <= 1'b0;
            end else if (set_vec[i]) begin
                q <= 1'b1;
            end else if (w1c_wr && wbits[i]) begin
                q <= 1'b0;
            end
        end
        assign tstat_q[i] = q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '1;
        end else if (men_wr) begin
            mask_q <= mask_q & ~wbits;
        end else if (mdis_wr) begin
            mask_q <= mask_q | wbits;
        end
    end

    assign irq = |(tstat_q & ~mask_q);

endmodule

// File: rtl/rng_irq_agg.sv
module rng_irq_agg
    import rng_irq_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              ev_done,
    input  logic              ev_ctest_fault,
    input  logic              ev_health_fault,
    input  logic              bus_err,
    input  logic              src_en,
    input  logic              hold_reset,
    input  logic              soft_rst,
    output logic              irq
);

    localparam int unsigned WUSE = 2 * NEV;

    mode_e           mode_q;
    logic            accept_done;
    logic            accept_fault;
    logic            held;
    logic [NEV-1:0]  ena_q;
    logic [NEV-1:0]  flags_q;
    logic            core_cond;
    logic [TS_W-1:0] tstat_q;
    logic [TS_W-1:0] mask_q;
    logic [TS_W-1:0] set_vec;
    logic [TS_W-1:0] kill_vec;
    logic            wipe;

    logic sel_ictl, sel_cstat, sel_tstat, sel_mask, sel_men, sel_mdis;

    assign sel_ictl  = (addr == ADDR_W'(OFS_ICTL));
    assign sel_cstat = (addr == ADDR_W'(OFS_CSTAT));
    assign sel_tstat = (addr == ADDR_W'(OFS_TSTAT));
    assign sel_mask  = (addr == ADDR_W'(OFS_MASK));
    assign sel_men   = (addr == ADDR_W'(OFS_MEN));
    assign sel_mdis  = (addr == ADDR_W'(OFS_MDIS));

    logic unused_wdata;
    assign unused_wdata = ^wdata[DATA_W-1:WUSE];

    assign wipe = soft_rst | held;

    rng_irq_mode_fsm u_mode (
        .clk          (clk),
        .rst_n        (rst_n),
        .hold_reset   (hold_reset),
        .src_en       (src_en),
        .mode         (mode_q),
        .accept_done  (accept_done),
        .accept_fault (accept_fault),
        .held         (held)
    );

    rng_irq_core_flags #(.NEV(NEV)) u_flags (
        .clk          (clk),
        .rst_n        (rst_n),
        .ev           ({ev_health_fault, ev_ctest_fault, ev_done}),
        .accept_done  (accept_done),
        .accept_fault (accept_fault),
        .wipe         (wipe),
        .ena_wr       (wr_en & sel_ictl),
        .ena_wdata    (wdata[NEV-1:0]),
        .clr          ((wr_en & sel_ictl) ? wdata[IC_CLR_LSB +: NEV] : '0),
        .ena_q        (ena_q),
        .flags_q      (flags_q),
        .core_cond    (core_cond)
    );

    always_comb begin
        set_vec           = '0;
        kill_vec          = '0;
        set_vec[TS_CORE]  = core_cond;
        set_vec[TS_SLV]   = bus_err;
        kill_vec[TS_CORE] = wipe;
    end

    rng_irq_top_level #(.TS_W(TS_W)) u_top (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_vec  (set_vec),
        .kill_vec (kill_vec),
        .w1c_wr   (wr_en & sel_tstat),
        .men_wr   (wr_en & sel_men),
        .mdis_wr  (wr_en & sel_mdis),
        .wbits    (wdata[TS_W-1:0]),
        .tstat_q  (tstat_q),
        .mask_q   (mask_q),
        .irq      (irq)
    );

    always_comb begin
        rdata = '0;
        if (sel_ictl) begin
            rdata[NEV-1:0] = ena_q;
        end else if (sel_cstat) begin
            rdata[CS_POS_DONE] = flags_q[0];
            rdata[CS_POS_CTF]  = flags_q[1];
            rdata[CS_POS_HTF]  = flags_q[2];
        end else if (sel_tstat) begin
            rdata[TS_W-1:0] = tstat_q;
        end else if (sel_mask) begin
            rdata[TS_W-1:0] = mask_q;
        end
    end

endmodule

// File: rtl/rng_irq_agg_chk.sv
module rng_irq_agg_chk
    import rng_irq_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic              soft_rst,
    input logic              irq,
    input mode_e             mode,
    input logic [NEV-1:0]    ena,
    input logic [NEV-1:0]    flags,
    input logic [TS_W-1:0]   tstat,
    input logic [TS_W-1:0]   mask
);

    // R6
    mask_direct_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(OFS_MASK)) |=> $stable(mask));

    // R7
    mask_enable_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(OFS_MEN) && wdata[0]) |=> !mask[0]);

    // R7
    mask_disable_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(OFS_MDIS) && wdata[1]) |=> mask[1]);

    // R8
    full_mask_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '1) |-> !irq);

    // R4
    core_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((|(flags & ena)) && !soft_rst && mode != MODE_HELD) |=> tstat[TS_CORE]);

    // R9
    soft_wipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (flags == '0 && !tstat[TS_CORE]));

    // R10
    held_wipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_HELD) |=> (flags == '0 && !tstat[TS_CORE]));

    // R10
    fault_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != MODE_LIVE && !flags[1]) |=> !flags[1]);

endmodule

bind rng_irq_agg rng_irq_agg_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .addr     (addr),
    .wdata    (wdata),
    .soft_rst (soft_rst),
    .irq      (irq),
    .mode     (mode_q),
    .ena      (ena_q),
    .flags    (flags_q),
    .tstat    (tstat_q),
    .mask     (mask_q)
);

// File: tb/test_rng_irq_agg.sv
module test_rng_irq_agg;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = 8'h00;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        ev_done = 1'b0, ev_ctest_fault = 1'b0, ev_health_fault = 1'b0;
    logic        bus_err = 1'b0, src_en = 1'b0, hold_reset = 1'b1, soft_rst = 1'b0;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    rng_irq_agg i_rng_irq_agg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .ev_done(ev_done), .ev_ctest_fault(ev_ctest_fault),
        .ev_health_fault(ev_health_fault), .bus_err(bus_err), .src_en(src_en),
        .hold_reset(hold_reset), .soft_rst(soft_rst), .irq(irq)
    );

    localparam logic [7:0] A_ICTL = 8'h00, A_CST = 8'h04, A_TST = 8'h08,
                           A_MSK = 8'h0C, A_MEN = 8'h10, A_MDIS = 8'h14;

    // {events[health,ctest,done], enables[health,ctest,done], expected core bit}
    localparam logic [6:0] VEC [6] = '{
        7'b001_001_1, 7'b010_001_0, 7'b100_100_1,
        7'b111_000_0, 7'b011_010_1, 7'b110_101_1
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic pulse_ev(input logic [2:0] e, input logic be, input logic sr);
        @(negedge clk);
        ev_done = e[0]; ev_ctest_fault = e[1]; ev_health_fault = e[2];
        bus_err = be; soft_rst = sr;
        @(negedge clk);
        ev_done = 1'b0; ev_ctest_fault = 1'b0; ev_health_fault = 1'b0;
        bus_err = 1'b0; soft_rst = 1'b0;
    endtask

    function automatic logic [31:0] cst_of(input logic [2:0] e);
        return {28'd0, e[2], 1'b0, e[1], e[0]};
    endfunction

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(A_MSK, d);  chk("R1 mask", d, 32'h3);
        rd(A_ICTL, d); chk("R1 ictl", d, 32'h0);
        rd(A_CST, d);  chk("R1 cstat", d, 32'h0);
        rd(A_TST, d);  chk("R1 tstat", d, 32'h0);
        chk("R1 irq", {31'd0, irq}, 32'h0);

        hold_reset = 1'b0; src_en = 1'b1;
        repeat (2) @(negedge clk);

        // R6 direct mask write ignored
        wr(A_MSK, 32'h0);
        rd(A_MSK, d);  chk("R6 mask write", d, 32'h3);
        // R7 mask enable / disable
        wr(A_MEN, 32'h1);
        rd(A_MSK, d);  chk("R7 mask enable", d, 32'h2);
        rd(A_MEN, d);  chk("R7 men reads 0", d, 32'h0);
        rd(A_MDIS, d); chk("R7 mdis reads 0", d, 32'h0);
        wr(A_MDIS, 32'h1);
        rd(A_MSK, d);  chk("R7 mask disable", d, 32'h3);
        wr(A_MEN, 32'h1);

        // R2 R4 R8 vector table
        for (int i = 0; i < 6; i++) begin
            pulse_ev(3'b000, 1'b0, 1'b1);
            wr(A_ICTL, {29'd0, VEC[i][3:1]});
            pulse_ev(VEC[i][6:4], 1'b0, 1'b0);
            rd(A_CST, d); chk("R2 flags", d, cst_of(VEC[i][6:4]));
            rd(A_TST, d); chk("R4 core bit", d, {31'd0, VEC[i][0]});
            chk("R8 irq core", {31'd0, irq}, {31'd0, VEC[i][0]});
        end

        // R3 readback of enables, clear bits read 0
        wr(A_ICTL, 32'h3F);
        rd(A_ICTL, d); chk("R3 ictl readback", d, 32'h7);
        rd(A_CST, d);  chk("R3 clear bits", d, 32'h0);

        // R4 W1C refused while condition holds
        pulse_ev(3'b000, 1'b0, 1'b1);
        wr(A_ICTL, 32'h1);
        pulse_ev(3'b001, 1'b0, 1'b0);
        wr(A_TST, 32'h1);
        rd(A_TST, d); chk("R4 w1c refused", d, 32'h1);
        wr(A_ICTL, 32'h9);
        rd(A_CST, d); chk("R3 clear done", d, 32'h0);
        rd(A_TST, d); chk("R4 core sticky", d, 32'h1);
        wr(A_TST, 32'h1);
        rd(A_TST, d); chk("R4 w1c accepted", d, 32'h0);

        // R2 strobe wins over clear in same cycle
        @(negedge clk);
        wr_en = 1'b1; addr = A_ICTL; wdata = 32'h08; ev_done = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0; ev_done = 1'b0;
        rd(A_CST, d); chk("R2 set wins", d, 32'h1);

        // R5 bus error bit, R8 masking
        pulse_ev(3'b000, 1'b0, 1'b1);
        pulse_ev(3'b000, 1'b1, 1'b0);
        rd(A_TST, d); chk("R5 slv set", d, 32'h2);
        chk("R8 slv masked", {31'd0, irq}, 32'h0);
        wr(A_MEN, 32'h2);
        #1 chk("R8 slv unmasked", {31'd0, irq}, 32'h1);
        wr(A_TST, 32'h0);
        rd(A_TST, d); chk("R5 write 0", d, 32'h2);

        // R9 soft reset keeps enables and bus error bit
        wr(A_ICTL, 32'h5);
        pulse_ev(3'b001, 1'b0, 1'b0);
        pulse_ev(3'b000, 1'b0, 1'b1);
        rd(A_CST, d);  chk("R9 flags wiped", d, 32'h0);
        rd(A_TST, d);  chk("R9 slv kept core cleared", d, 32'h2);
        rd(A_ICTL, d); chk("R9 enables kept", d, 32'h5);
        wr(A_TST, 32'h2);
        rd(A_TST, d);  chk("R5 slv cleared", d, 32'h0);
        chk("R8 irq low", {31'd0, irq}, 32'h0);

        // R10 quiet mode: faults ignored, done accepted
        wr(A_ICTL, 32'h0);
        @(negedge clk); src_en = 1'b0;
        @(negedge clk);
        pulse_ev(3'b110, 1'b0, 1'b0);
        rd(A_CST, d); chk("R10 faults ignored", d, 32'h0);
        pulse_ev(3'b001, 1'b0, 1'b0);
        rd(A_CST, d); chk("R10 done accepted", d, 32'h1);
        // R10 held mode
        @(negedge clk); hold_reset = 1'b1;
        @(negedge clk);
        pulse_ev(3'b111, 1'b0, 1'b0);
        rd(A_CST, d); chk("R10 held wipe", d, 32'h0);
        @(negedge clk); hold_reset = 1'b0; src_en = 1'b1;
        @(negedge clk);
        pulse_ev(3'b010, 1'b0, 1'b0);
        rd(A_CST, d); chk("R10 live fault", d, 32'h2);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule